// File: doc/BRIEF.md
# ARINC 429 Transmit Channel

This block is one transmit lane of an avionics serial controller. A host hands it 32-bit words as two 16-bit writes, the lower half first and the upper half second. Each finished word waits in a small first-in first-out queue. When the lane is enabled, the block takes the oldest word, replaces its top bit with a parity bit if a parity mode is selected, and shifts it out least significant bit first.

The word goes out on a pair of return-to-zero lines. A "one" bit is a pulse on one line and a "zero" bit is a pulse on the other. Each pulse fills the first half of its bit period, and both lines rest low in the second half. The bit rate comes from a programmable half-period count in system clocks. After every word the lines stay quiet for a fixed null gap before the next word may start.

Two single-cycle interrupt causes tell the host what has happened. One fires when the queue has just been drained. The other fires when the last gap ends and nothing is waiting. A sticky flag records writes that arrived while the queue was full.

Top module: `arinc_tx_chan`

## Requirements
- R1: A write with `wr_upper`=0 only stores the lower 16 bits and queues nothing. A write with `wr_upper`=1 queues the word {upper data, last stored lower half}.
- R2: The queue holds up to 8 words. A completing write while 8 words are queued is dropped, and it sets `ovf_flag`, which stays set until reset.
- R3: A 1 bit pulses `line_one` and a 0 bit pulses `line_zero`. The two lines are never high together. Bits go out in order from bit 0 to bit 31.
- R4: With `half_div`=H (H≥1), each pulse is high for H clocks and is followed by H low clocks before the next bit of the same word.
- R5: `par_mode` 2'b01 (odd) sets bit 31 so that the 32 sent bits hold an odd number of ones. 2'b10 (even) makes that number even. 2'b00 and 2'b11 send bit 31 as written.
- R6: Queued words go out back to back, with 4 bit times of null after each word, so that successive word starts are 72·H clocks apart.
- R7: `irq_empty` pulses for one cycle each time the last queued word is taken for sending.
- R8: `irq_eot` pulses for one cycle when a word's null gap ends and the queue is empty.
- R9: While `tx_enable` is low no new word starts, but a word already started completes. After such a stop `irq_eot` stays low while words remain queued.
- R10: After reset both lines are low, both interrupt causes are low, `ovf_flag` is clear and the queue is empty.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Host write strobe, one cycle per write |
| wr_upper | input | 1 | 0: lower half write, 1: upper half write that queues the word |
| wr_data | input | 16 | Half-word write data |
| tx_enable | input | 1 | Allows new words to start |
| par_mode | input | 2 | 00 none, 01 odd, 10 even, 11 none |
| half_div | input | DIV_W | Clocks per half bit period |
| line_one | output | 1 | Return-to-zero "one" line |
| line_zero | output | 1 | Return-to-zero "zero" line |
| irq_empty | output | 1 | Pulse: queue just drained |
| irq_eot | output | 1 | Pulse: transmission finished with queue empty |
| ovf_flag | output | 1 | Sticky: a write was dropped on a full queue |

## Verification
The bench builds the block with its defaults: DEPTH=8, GAP_BITS=4 and DIV_W=16. It changes the half period at run time between 2, 3 and 5 clocks. With those values one word plus its gap takes 144 to 360 clocks, so the bench can fill the whole queue, reach overflow on the ninth write, and drain all eight words within a short run. The serial lines are decoded by a bench-side receiver. The word values, pulse widths, low widths and start-to-start spacing are compared against values worked out from the requirements.

// File: rtl/arinc_tx_pkg.sv
package arinc_tx_pkg;

  localparam int WORD_W = 32;
  localparam int HALF_W = 16;

  typedef enum logic [1:0] {
    PAR_NONE = 2'b00,
    PAR_ODD  = 2'b01,
    PAR_EVEN = 2'b10,
    PAR_RAW  = 2'b11
  } par_mode_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'b00,
    ST_SEND = 2'b01,
    ST_GAP  = 2'b10
  } tx_state_e;

  // Put the parity bit into bit 31 according to the selected mode
  function automatic logic [WORD_W-1:0] add_parity(logic [WORD_W-1:0] w, par_mode_e m);
    logic [WORD_W-1:0] r;
    r = w;
    case (m)
      PAR_ODD:  r[WORD_W-1] = ~(^w[WORD_W-2:0]);
      PAR_EVEN: r[WORD_W-1] = ^w[WORD_W-2:0];
      default:  r[WORD_W-1] = w[WORD_W-1];
    endcase
    return r;
  endfunction

endpackage

// File: rtl/atx_fifo.sv
module atx_fifo #(
  parameter int W     = 32,
  parameter int DEPTH = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         empty,
  output logic         drained,
  output logic         ovf
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp_q, rp_q, wp_d, rp_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          ovf_q, ovf_d, drn_q, drn_d;
  logic          full, do_push, do_pop;

  assign full    = (cnt_q == CW'(DEPTH));
  assign empty   = (cnt_q == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign dout    = mem[rp_q];

  always_comb begin
    wp_d  = wp_q;
    rp_d  = rp_q;
    cnt_d = cnt_q;
    if (do_push) wp_d = (wp_q == AW'(DEPTH - 1)) ? '0 : wp_q + AW'(1);
    if (do_pop)  rp_d = (rp_q == AW'(DEPTH - 1)) ? '0 : rp_q + AW'(1);
    if (do_push && !do_pop)      cnt_d = cnt_q + CW'(1);
    else if (do_pop && !do_push) cnt_d = cnt_q - CW'(1);
    ovf_d = ovf_q | (push && full);
    drn_d = do_pop && !do_push && (cnt_q == CW'(1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
      ovf_q <= 1'b0;
      drn_q <= 1'b0;
    end else begin
      wp_q  <= wp_d;
      rp_q  <= rp_d;
      cnt_q <= cnt_d;
      ovf_q <= ovf_d;
      drn_q <= drn_d;
    end
  end

  // Storage has no reset; only written entries are ever read
  always_ff @(posedge clk) begin
    if (do_push) mem[wp_q] <= din;
  end

  assign ovf     = ovf_q;
  assign drained = drn_q;

  p_no_overflow_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (push && full && !pop) |=> ($stable(cnt_q) && ovf_q));
  p_count_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(DEPTH));
  p_ovf_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_q |=> ovf_q);

endmodule

// File: rtl/atx_rate_gen.sv
module atx_rate_gen #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic [DW-1:0] half_div,
  output logic          tick
);
  logic [DW-1:0] cnt_q, cnt_d;

  // A half_div of 0 behaves like 1
  assign tick = run && ((cnt_q + DW'(1)) >= half_div);

  always_comb begin
    if (!run || tick) cnt_d = '0;
    else              cnt_d = cnt_q + DW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  p_idle_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (cnt_q == '0));

endmodule

// File: rtl/atx_serializer.sv
module atx_serializer
  import arinc_tx_pkg::*;
#(
  parameter int GAP_BITS = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  par_mode_e         mode,
  input  logic              q_empty,
  input  logic [WORD_W-1:0] q_head,
  input  logic              tick,
  output logic              q_pop,
  output logic              busy,
  output logic              line_one,
  output logic              line_zero,
  output logic              eot
);
  localparam int GAP_HALVES = 2 * GAP_BITS;
  localparam int GW         = $clog2(GAP_HALVES);
  localparam int BW         = $clog2(WORD_W);

  tx_state_e         st_q, st_d;
  logic [WORD_W-1:0] sh_q, sh_d;
  logic [BW-1:0]     bit_q, bit_d;
  logic [GW-1:0]     gap_q, gap_d;
  logic              ph_q, ph_d;
  logic              eot_q, eot_d;
  logic              start_ok;

  assign start_ok = enable && !q_empty;

  always_comb begin
    st_d  = st_q;
    sh_d  = sh_q;
    bit_d = bit_q;
    gap_d = gap_q;
    ph_d  = ph_q;
    eot_d = 1'b0;
    q_pop = 1'b0;
    case (st_q)
      ST_IDLE: begin
        if (start_ok) begin
          q_pop = 1'b1;
          st_d  = ST_SEND;
          sh_d  = add_parity(q_head, mode);
          bit_d = '0;
          ph_d  = 1'b0;
        end
      end
      ST_SEND: begin
        if (tick) begin
          if (!ph_q) begin
            ph_d = 1'b1;
          end else begin
            ph_d = 1'b0;
            sh_d = sh_q >> 1;
            if (bit_q == BW'(WORD_W - 1)) begin
              st_d  = ST_GAP;
              gap_d = '0;
            end else begin
              bit_d = bit_q + BW'(1);
            end
          end
        end
      end
      ST_GAP: begin
        if (tick) begin
          if (gap_q == GW'(GAP_HALVES - 1)) begin
            if (start_ok) begin
              q_pop = 1'b1;
              st_d  = ST_SEND;
              sh_d  = add_parity(q_head, mode);
              bit_d = '0;
              ph_d  = 1'b0;
            end else begin
              st_d  = ST_IDLE;
              eot_d = q_empty;
            end
          end else begin
            gap_d = gap_q + GW'(1);
          end
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      sh_q  <= '0;
      bit_q <= '0;
      gap_q <= '0;
      ph_q  <= 1'b0;
      eot_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      sh_q  <= sh_d;
      bit_q <= bit_d;
      gap_q <= gap_d;
      ph_q  <= ph_d;
      eot_q <= eot_d;
    end
  end

  assign busy      = (st_q != ST_IDLE);
  assign line_one  = (st_q == ST_SEND) && !ph_q && sh_q[0];
  assign line_zero = (st_q == ST_SEND) && !ph_q && !sh_q[0];
  assign eot       = eot_q;

  p_lines_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(line_one && line_zero));
  p_phase_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_SEND && !tick) |=> $stable(ph_q));
  p_eot_after_gap_r8: assert property (@(posedge clk) disable iff (!rst_n)
    eot_q |-> (st_q == ST_IDLE && $past(st_q) == ST_GAP));
  p_pop_nonempty_r9: assert property (@(posedge clk) disable iff (!rst_n)
    q_pop |-> (enable && !q_empty));

endmodule

// File: rtl/arinc_tx_chan.sv
module arinc_tx_chan
  import arinc_tx_pkg::*;
#(
  parameter int DEPTH    = 8,
  parameter int DIV_W    = 16,
  parameter int GAP_BITS = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             wr_upper,
  input  logic [15:0]      wr_data,
  input  logic             tx_enable,
  input  logic [1:0]       par_mode,
  input  logic [DIV_W-1:0] half_div,
  output logic             line_one,
  output logic             line_zero,
  output logic             irq_empty,
  output logic             irq_eot,
  output logic             ovf_flag
);
  logic [1:0]        rs_q;
  logic              rst_s_n;
  logic [HALF_W-1:0] lo_q;
  logic [WORD_W-1:0] head;
  logic              push, pop, empty, tick, busy;

  // Reset asserts at once and leaves after two clock edges
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_s_n = rs_q[1];

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n)              lo_q <= '0;
    else if (wr_en && !wr_upper) lo_q <= wr_data;
  end

  assign push = wr_en && wr_upper;

  atx_fifo #(.W(WORD_W), .DEPTH(DEPTH)) u_fifo (
    .clk     (clk),
    .rst_n   (rst_s_n),
    .push    (push),
    .din     ({wr_data, lo_q}),
    .pop     (pop),
    .dout    (head),
    .empty   (empty),
    .drained (irq_empty),
    .ovf     (ovf_flag)
  );

  atx_rate_gen #(.DW(DIV_W)) u_rate (
    .clk      (clk),
    .rst_n    (rst_s_n),
    .run      (busy),
    .half_div (half_div),
    .tick     (tick)
  );

  atx_serializer #(.GAP_BITS(GAP_BITS)) u_ser (
    .clk       (clk),
    .rst_n     (rst_s_n),
    .enable    (tx_enable),
    .mode      (par_mode_e'(par_mode)),
    .q_empty   (empty),
    .q_head    (head),
    .tick      (tick),
    .q_pop     (pop),
    .busy      (busy),
    .line_one  (line_one),
    .line_zero (line_zero),
    .eot       (irq_eot)
  );

  p_lower_only_r1: assert property (@(posedge clk) disable iff (!rst_s_n)
    (wr_en && !wr_upper) |=> (lo_q == $past(wr_data)));
  p_irq_excl_r7: assert property (@(posedge clk) disable iff (!rst_s_n)
    irq_eot |-> !busy);

endmodule

// File: tb/arinc_tx_chan_bench.sv
`timescale 1ns/1ps
module arinc_tx_chan_bench;
  logic        clk, rst_n, wr_en, wr_upper, tx_enable;
  logic [15:0] wr_data, half_div;
  logic [1:0]  par_mode;
  logic        line_one, line_zero, irq_empty, irq_eot, ovf_flag;

  arinc_tx_chan u_arinc_tx_chan (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_upper(wr_upper), .wr_data(wr_data),
    .tx_enable(tx_enable), .par_mode(par_mode), .half_div(half_div),
    .line_one(line_one), .line_zero(line_zero), .irq_empty(irq_empty),
    .irq_eot(irq_eot), .ovf_flag(ovf_flag)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // ---------------- bench-side line receiver ----------------
  int          cyc = 0, nw = 0, bitn = 0, hi_len = 0, lo_len = 0;
  int          shape_err = 0, both_err = 0, eot_cnt = 0, fe_cnt = 0;
  logic        prev_any = 1'b0;
  logic [31:0] sh = '0;
  logic [31:0] rx_words [32];
  int          t_start  [32];

  always @(negedge clk) begin
    logic any;
    any = line_one | line_zero;
    cyc++;
    if (irq_eot)   eot_cnt++;
    if (irq_empty) fe_cnt++;
    if (line_one && line_zero) both_err++;
    if (any && !prev_any) begin
      if (bitn != 0 && lo_len != int'(half_div)) shape_err++;
      if (bitn == 0 && nw < 32) t_start[nw] = cyc;
      sh = {line_one, sh[31:1]};
      bitn++;
      hi_len = 1;
      if (bitn == 32) begin
        if (nw < 32) rx_words[nw] = sh;
        nw++;
        bitn = 0;
      end
    end else if (any) begin
      hi_len++;
    end else begin
      if (prev_any) begin
        if (hi_len != int'(half_div)) shape_err++;
        lo_len = 1;
      end else begin
        lo_len++;
      end
    end
    prev_any = any;
  end

  // ---------------- checking ----------------
  int total = 0, fails = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic upper, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_upper = upper; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wr_word(input logic [31:0] w);
    wr(1'b0, w[15:0]);
    wr(1'b1, w[31:16]);
  endtask

  task automatic wait_words(input int n, input int limit);
    for (int i = 0; i < limit && nw < n; i++) @(negedge clk);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  typedef struct packed {
    logic [31:0] din;
    logic [1:0]  mode;
    logic [31:0] exp;
  } vec_t;

  localparam vec_t VEC [8] = '{
    '{32'h0000_0001, 2'b00, 32'h0000_0001},
    '{32'h0000_0001, 2'b01, 32'h0000_0001},
    '{32'h0000_0001, 2'b10, 32'h8000_0001},
    '{32'h8000_0003, 2'b01, 32'h8000_0003},
    '{32'h8000_0003, 2'b10, 32'h0000_0003},
    '{32'hFFFF_FFFF, 2'b00, 32'hFFFF_FFFF},
    '{32'h7FFF_FFFF, 2'b01, 32'h7FFF_FFFF},
    '{32'h1234_5678, 2'b10, 32'h9234_5678}
  };

  // Watchdog: counts as one failed check and still prints the summary
  initial begin
    repeat (150000) @(posedge clk);
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", total - fails, total + 1);
    $finish;
  end

  initial begin
    int base, e0, f0;
    rst_n = 1'b0; wr_en = 1'b0; wr_upper = 1'b0; wr_data = '0;
    tx_enable = 1'b0; par_mode = 2'b00; half_div = 16'd2;
    idle(5);
    rst_n = 1'b1;
    idle(5);

    // R10: reset state
    chk("R10 line_one",  {31'd0, line_one},  32'd0);
    chk("R10 line_zero", {31'd0, line_zero}, 32'd0);
    chk("R10 irq",       {30'd0, irq_empty, irq_eot}, 32'd0);
    chk("R10 ovf_flag",  {31'd0, ovf_flag},  32'd0);

    // R3 R5 R7 R8: vector table, one word at a time, H=2
    tx_enable = 1'b1;
    for (int k = 0; k < 8; k++) begin
      e0 = eot_cnt; f0 = fe_cnt;
      par_mode = VEC[k].mode;
      wr_word(VEC[k].din);
      wait_words(k + 1, 400);
      idle(40);
      chk("R5 R3 parity and bit order", rx_words[k], VEC[k].exp);
      chk("R8 eot pulse once", eot_cnt - e0, 1);
      chk("R7 empty pulse once", fe_cnt - f0, 1);
    end
    chk("R4 pulse and low widths H=2", shape_err, 0);
    chk("R3 lines exclusive", both_err, 0);

    // R1: lower half alone queues nothing; upper half commits held lower
    par_mode = 2'b00;
    base = nw;
    wr(1'b0, 16'h5555);
    idle(400);
    chk("R1 lower half only sends nothing", nw - base, 0);
    wr(1'b1, 16'h0F0F);
    wait_words(base + 1, 400);
    chk("R1 committed word", rx_words[base], 32'h0F0F_5555);
    idle(40);

    // R6: three queued words start 72*H apart, H=3
    tx_enable = 1'b0;
    half_div = 16'd3;
    base = nw;
    wr_word(32'h0000_00A1);
    wr_word(32'h0000_00B2);
    wr_word(32'h0000_00C3);
    e0 = eot_cnt; f0 = fe_cnt;
    tx_enable = 1'b1;
    wait_words(base + 3, 1500);
    idle(40);
    chk("R6 spacing word 1-2", t_start[base + 1] - t_start[base], 216);
    chk("R6 spacing word 2-3", t_start[base + 2] - t_start[base + 1], 216);
    chk("R6 third word", rx_words[base + 2], 32'h0000_00C3);
    chk("R8 single eot after burst", eot_cnt - e0, 1);
    chk("R7 single empty after burst", fe_cnt - f0, 1);
    chk("R4 widths H=3", shape_err, 0);

    // R9: disable during a word: it completes, the next waits, no eot
    tx_enable = 1'b0;
    base = nw;
    wr_word(32'h1111_2222);
    wr_word(32'h3333_4444);
    e0 = eot_cnt;
    tx_enable = 1'b1;
    idle(20);
    tx_enable = 1'b0;
    idle(800);
    chk("R9 in-flight word completes", nw - base, 1);
    chk("R9 first word value", rx_words[base], 32'h1111_2222);
    chk("R9 no eot while queued", eot_cnt - e0, 0);
    tx_enable = 1'b1;
    wait_words(base + 2, 800);
    idle(40);
    chk("R9 second word after re-enable", rx_words[base + 1], 32'h3333_4444);
    chk("R8 eot after last", eot_cnt - e0, 1);

    // R2: nine writes on a stalled queue, only eight sent
    tx_enable = 1'b0;
    half_div = 16'd2;
    base = nw;
    for (int i = 0; i < 9; i++) wr_word(32'hA000_0000 + i);
    chk("R2 overflow flag set", {31'd0, ovf_flag}, 32'd1);
    tx_enable = 1'b1;
    wait_words(base + 8, 2000);
    idle(600);
    chk("R2 eight words sent", nw - base, 8);
    chk("R2 first queued", rx_words[base], 32'hA000_0000);
    chk("R2 eighth queued", rx_words[base + 7], 32'hA000_0007);
    chk("R2 flag sticky", {31'd0, ovf_flag}, 32'd1);

    // R4: slower rate H=5
    half_div = 16'd5;
    base = nw;
    wr_word(32'h0F0F_A5A5);
    wait_words(base + 1, 800);
    idle(60);
    chk("R4 word at H=5", rx_words[base], 32'h0F0F_A5A5);
    chk("R4 widths H=5", shape_err, 0);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule